// File: doc/BRIEF.md
# Repeated Instruction Sequencer

This control block drives the repeat mode of a processor's main control, in which one instruction is executed many times without new fetches. On a start strobe it captures the repeat-count word, the address of the instruction that set up the repeat and the address of the next instruction. It then issues one single-cycle execute strobe per iteration. After each completion it counts the remaining-iteration field down, and it stops when the count is exhausted, when the repeated function requests a jump or skip, or when an interrupt is pending at an iteration boundary.

While the block is busy, the next-instruction address is parked in the T register and P is not used for fetching. P holds the address of the setup instruction, so an interrupt leaves P pointing at that instruction. The remaining count stays in the count word, and a return from the interrupt re-runs the setup instruction and resumes with only the iterations still owed. A normal end restores P from T. A jump or skip end loads P with the address supplied by the repeated function. A one-cycle done strobe marks each end, and a status code reports which kind of end occurred.

Top module: `rpt_sequencer`

## Requirements
- R1: After reset, busy_o, exec_o and done_o are 0, term_o is 0 (none), and p_o, t_o and rc_word_o are all zero.
- R2: A start_i pulse while idle captures rc_word_i, loads t_o with next_addr_i and p_o with setup_addr_i, and raises busy_o. While busy, t_o and the upper half of the count word (bits 35:18) hold their captured values.
- R3: At each iteration boundary with a nonzero count field (bits 17:0) and no interrupt pending, exec_o pulses for exactly one cycle. Each iter_done_i received after a strobe lowers the count field by one.
- R4: When the count field is zero at a boundary, the run ends normally: done_o pulses, term_o becomes 1, p_o takes the value of t_o and the count field reads 0.
- R5: A start with a count field of zero issues no execute strobe and ends normally (term_o = 1) with p_o equal to next_addr_i.
- R6: If intr_i is high at a boundary with a nonzero count, no strobe is issued and the run ends with term_o = 3. p_o keeps setup_addr_i, and the count field holds the iterations not yet executed.
- R7: intr_i is sampled only at iteration boundaries. An interrupt that is raised while an iteration is in progress and dropped before its completion has no effect on the run.
- R8: jump_i high together with iter_done_i ends the run with term_o = 2 and p_o = jump_addr_i. The count field equals the initial count minus the iterations executed, including the one that jumped.
- R9: At a boundary, an exhausted count takes priority over a pending interrupt, so an interrupt at the final boundary yields a normal end.
- R10: start_i is ignored while busy: the captured addresses, the count word and the outcome of the run are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only when idle |
| setup_addr_i | input | AW | Address of the instruction that set up the repeat |
| next_addr_i | input | AW | Address of the instruction after the repeat |
| rc_word_i | input | 2*KW | Repeat-count word; the count is in bits KW-1:0 |
| exec_o | output | 1 | Execute strobe, one per iteration |
| iter_done_i | input | 1 | Completion of the current iteration |
| jump_i | input | 1 | Jump or skip termination, qualified by iter_done_i |
| jump_addr_i | input | AW | P value for a jump or skip termination |
| intr_i | input | 1 | Pending interrupt, sampled at iteration boundaries |
| busy_o | output | 1 | Repeat in progress; P is not used for fetching |
| done_o | output | 1 | One-cycle termination strobe |
| term_o | output | 2 | Termination kind: 0 none, 1 normal, 2 jump/skip, 3 interrupt |
| p_o | output | AW | Program counter P |
| t_o | output | AW | Parked next-instruction address T |
| rc_word_o | output | 2*KW | Current repeat-count word |

## Verification
The assertions check on every cycle that each execute strobe lasts one cycle and never fires with a zero count, and that the count never wraps below zero. They also check that T and the upper half of the count word stay fixed between starts, that done pulses for one cycle, and that a normal end leaves a zero count with P equal to T. Only the bench's scenarios can show the choice between the three kinds of end and the resulting P and remaining count. The same holds for the boundary priority of an exhausted count over an interrupt, for interrupts raised and dropped within an iteration having no effect, and for start strobes ignored while busy.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
  typedef enum logic [1:0] {
    TERM_NONE   = 2'd0,
    TERM_NORMAL = 2'd1,
    TERM_JUMP   = 2'd2,
    TERM_INTR   = 2'd3
  } term_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BOUND = 2'd1,
    ST_WAIT  = 2'd2
  } st_e;
endpackage

// File: rtl/rpt_count.sv
module rpt_count #(
  parameter int KW = 18
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [2*KW-1:0] word_i,
  input  logic            dec_i,
  output logic [2*KW-1:0] word_o,
  output logic            zero_o
);
  localparam int WW = 2 * KW;

  logic [WW-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
    end else if (load_i) begin
      word_q <= word_i;
    end else if (dec_i) begin
      word_q[KW-1:0] <= word_q[KW-1:0] - KW'(1);
    end
  end

  assign word_o = word_q;
  assign zero_o = (word_q[KW-1:0] == '0);

  // R3
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> !zero_o);

  // R2
  park_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(word_q[WW-1:KW]));
endmodule

// File: rtl/rpt_addr.sv
module rpt_addr #(
  parameter int AW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] setup_i,
  input  logic [AW-1:0] next_i,
  input  logic          fin_normal_i,
  input  logic          fin_jump_i,
  input  logic [AW-1:0] jump_addr_i,
  output logic [AW-1:0] p_o,
  output logic [AW-1:0] t_o
);
  logic [AW-1:0] p_q, t_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_q <= '0;
      t_q <= '0;
    end else begin
      if (load_i) begin
        p_q <= setup_i;
        t_q <= next_i;
      end else if (fin_normal_i) begin
        p_q <= t_q;
      end else if (fin_jump_i) begin
        p_q <= jump_addr_i;
      end
    end
  end

  assign p_o = p_q;
  assign t_o = t_q;

  // R2
  t_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(t_q));
endmodule

// File: rtl/rpt_ctrl.sv
module rpt_ctrl
  import rpt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       zero_i,
  input  logic       intr_i,
  input  logic       iter_done_i,
  input  logic       jump_i,
  output logic       load_o,
  output logic       dec_o,
  output logic       exec_o,
  output logic       fin_normal_o,
  output logic       fin_jump_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [1:0] term_o
);
  st_e   st_q, st_d;
  term_e term_q;
  logic  done_q;
  logic  at_bound, fin_intr;

  assign at_bound     = (st_q == ST_BOUND);
  assign load_o       = (st_q == ST_IDLE) && start_i;
  assign fin_normal_o = at_bound && zero_i;            // count wins over interrupt
  assign fin_intr     = at_bound && !zero_i && intr_i;
  assign exec_o       = at_bound && !zero_i && !intr_i;
  assign dec_o        = (st_q == ST_WAIT) && iter_done_i;
  assign fin_jump_o   = dec_o && jump_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_i) st_d = ST_BOUND;
      ST_BOUND: st_d = exec_o ? ST_WAIT : ST_IDLE;
      ST_WAIT:  if (dec_o) st_d = jump_i ? ST_IDLE : ST_BOUND;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      term_q <= TERM_NONE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= fin_normal_o | fin_intr | fin_jump_o;
      if (load_o)            term_q <= TERM_NONE;
      else if (fin_normal_o) term_q <= TERM_NORMAL;
      else if (fin_intr)     term_q <= TERM_INTR;
      else if (fin_jump_o)   term_q <= TERM_JUMP;
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;
  assign term_o = term_q;

  // R3
  exec_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o |=> !exec_o);

  // R4
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R4
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && term_o != TERM_NONE);
endmodule

// File: rtl/rpt_sequencer.sv
module rpt_sequencer
  import rpt_pkg::*;
#(
  parameter int AW = 18,
  parameter int KW = 18
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [AW-1:0]   setup_addr_i,
  input  logic [AW-1:0]   next_addr_i,
  input  logic [2*KW-1:0] rc_word_i,
  output logic            exec_o,
  input  logic            iter_done_i,
  input  logic            jump_i,
  input  logic [AW-1:0]   jump_addr_i,
  input  logic            intr_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [1:0]      term_o,
  output logic [AW-1:0]   p_o,
  output logic [AW-1:0]   t_o,
  output logic [2*KW-1:0] rc_word_o
);
  logic load, dec, zero, fin_normal, fin_jump;

  rpt_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .zero_i       (zero),
    .intr_i       (intr_i),
    .iter_done_i  (iter_done_i),
    .jump_i       (jump_i),
    .load_o       (load),
    .dec_o        (dec),
    .exec_o       (exec_o),
    .fin_normal_o (fin_normal),
    .fin_jump_o   (fin_jump),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .term_o       (term_o)
  );

  rpt_count #(.KW(KW)) u_count (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .word_i (rc_word_i),
    .dec_i  (dec),
    .word_o (rc_word_o),
    .zero_o (zero)
  );

  rpt_addr #(.AW(AW)) u_addr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load),
    .setup_i      (setup_addr_i),
    .next_i       (next_addr_i),
    .fin_normal_i (fin_normal),
    .fin_jump_i   (fin_jump),
    .jump_addr_i  (jump_addr_i),
    .p_o          (p_o),
    .t_o          (t_o)
  );

  // R3
  exec_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o |-> rc_word_o[KW-1:0] != '0);

  // R4
  normal_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && term_o == TERM_NORMAL |-> rc_word_o[KW-1:0] == '0);

  // R4
  normal_p_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && term_o == TERM_NORMAL |-> p_o == t_o);
endmodule

// File: tb/rpt_sequencer_test.sv
`timescale 1ns/1ps
module rpt_sequencer_test;
  localparam int AW = 18;
  localparam int KW = 18;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            start_i = 1'b0;
  logic [AW-1:0]   setup_addr_i = '0;
  logic [AW-1:0]   next_addr_i = '0;
  logic [2*KW-1:0] rc_word_i = '0;
  logic            exec_o;
  logic            iter_done_i = 1'b0;
  logic            jump_i = 1'b0;
  logic [AW-1:0]   jump_addr_i = '0;
  logic            intr_i = 1'b0;
  logic            busy_o, done_o;
  logic [1:0]      term_o;
  logic [AW-1:0]   p_o, t_o;
  logic [2*KW-1:0] rc_word_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rpt_sequencer #(.AW(AW), .KW(KW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .setup_addr_i(setup_addr_i), .next_addr_i(next_addr_i),
    .rc_word_i(rc_word_i), .exec_o(exec_o), .iter_done_i(iter_done_i),
    .jump_i(jump_i), .jump_addr_i(jump_addr_i), .intr_i(intr_i),
    .busy_o(busy_o), .done_o(done_o), .term_o(term_o),
    .p_o(p_o), .t_o(t_o), .rc_word_o(rc_word_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_execs(int k, int jat, int iat);
    if (jat >= 1 && jat <= k && (iat < 0 || iat >= jat)) return jat;
    if (iat >= 0 && iat < k) return iat;
    return k;
  endfunction

  function automatic int exp_term(int k, int jat, int iat);
    if (jat >= 1 && jat <= k && (iat < 0 || iat >= jat)) return 2;
    if (iat >= 0 && iat < k) return 3;
    return 1;
  endfunction

  // jat: iteration that jumps (0 none); iat: boundary with interrupt (-1 none)
  task automatic run(input int k, input logic [KW-1:0] hi, input int jat, input int iat,
                     input bit noise, input string tag);
    logic [AW-1:0] sa, na, ja;
    logic [2*KW-1:0] w;
    int execs, dly, guard, et;
    bit pend, intr_hold, first;
    sa = AW'($urandom); na = AW'($urandom); ja = AW'($urandom);
    w = {hi, KW'(k)};
    execs = 0; pend = 0; dly = 0; guard = 0; first = 1;
    intr_hold = (iat == 0);
    @(negedge clk);
    setup_addr_i = sa; next_addr_i = na; rc_word_i = w; jump_addr_i = ja;
    start_i = 1'b1; intr_i = intr_hold;
    forever begin
      @(negedge clk);
      start_i = 1'b0; iter_done_i = 1'b0; jump_i = 1'b0;
      setup_addr_i = sa; next_addr_i = na; rc_word_i = w;
      if (!intr_hold) intr_i = 1'b0;
      if (done_o) break;
      guard++;
      if (guard > 5000) begin
        chk({tag, " R3 run hung"}, 0, 1);
        break;
      end
      if (exec_o) begin
        execs++; pend = 1; dly = int'($urandom % 3);
        if (first) begin
          // R2 captured state while busy
          chk({tag, " R2 p while busy"}, p_o, sa);
          chk({tag, " R2 busy"}, busy_o, 1);
          first = 0;
        end
      end else if (pend) begin
        if (dly == 0) begin
          iter_done_i = 1'b1;
          jump_i = (execs == jat);
          if (execs == iat) begin intr_hold = 1; intr_i = 1'b1; end
          pend = 0;
        end else begin
          dly--;
          if (noise) begin
            intr_i = 1'b1;       // R7 mid-iteration interrupt, dropped before completion
            start_i = 1'b1;      // R10 start while busy
            setup_addr_i = ~sa; next_addr_i = ~na; rc_word_i = ~w;
          end
        end
      end
    end
    intr_i = 1'b0;
    et = exp_term(k, jat, iat);
    chk({tag, " R3 exec count"}, execs, exp_execs(k, jat, iat));
    chk({tag, " R4 term"}, term_o, et);
    chk({tag, " R2 t"}, t_o, na);
    chk({tag, " R2 upper half"}, rc_word_o[2*KW-1:KW], hi);
    chk({tag, " R3 remaining k"}, rc_word_o[KW-1:0], k - exp_execs(k, jat, iat));
    if (et == 1)      chk({tag, " R4 p normal"}, p_o, na);
    else if (et == 2) chk({tag, " R8 p jump"}, p_o, ja);
    else              chk({tag, " R6 p intr"}, p_o, sa);
    @(negedge clk);
    chk({tag, " R4 done one cycle"}, done_o, 0);
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20241107));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy_o, 0);
    chk("R1 exec", exec_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 term", term_o, 0);
    chk("R1 p", p_o, 0);
    chk("R1 t", t_o, 0);
    chk("R1 word", rc_word_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    run(0,   18'h0,     0, -1, 0, "R5 zero count");
    run(0,   18'h3ffff, 0,  0, 0, "R5 zero count intr");
    run(5,   18'h12345, 0, -1, 0, "R4 normal");
    run(300, 18'h2aaaa, 0, -1, 0, "R4 long");
    run(4,   18'h1,     0,  0, 0, "R6 intr first boundary");
    run(6,   18'h5,     0,  3, 0, "R6 intr mid");
    run(4,   18'h7,     0,  4, 0, "R9 intr final boundary");
    run(5,   18'h9,     1, -1, 0, "R8 jump first");
    run(5,   18'hb,     5, -1, 0, "R8 jump last");
    run(5,   18'hc,     3,  3, 0, "R8 jump beats intr");
    run(6,   18'hd,     0, -1, 1, "R7 R10 noise normal");
    run(6,   18'he,     4,  2, 1, "R7 R10 noise intr");

    for (int i = 0; i < 40; i++) begin
      int k, jat, iat;
      k   = int'($urandom % 10);
      jat = ($urandom % 3 == 0) ? int'($urandom % (k + 2)) : 0;
      iat = ($urandom % 3 == 0) ? int'($urandom % (k + 1)) : -1;
      run(k, KW'($urandom), jat, iat, bit'($urandom % 2), "R3 R6 R7 R8 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule